// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block sits in the front end of a synchronous burst SRAM. It loads a starting address and then steps through the rest of a four-beat burst, so the array sees a new address on every beat without a new address from the bus. A load can come from either of two active-low address strobes. One is used by a processor and is qualified by chip enable. The other is used by a memory controller and always loads.

Only the low `BEAT_W` bits of the address move during a burst (two bits by default, which gives four beats). The upper bits stay as they were loaded. The beat number goes up by one on each cycle that the active-low advance input is asserted. A static order-select pin sets how the beat number maps onto the low address bits. With the pin low the order is linear (start plus beat, wrapping within the burst). With the pin high the order is interleaved (start XOR beat). The order-select pin is not clocked. When it changes, the output changes within the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with no strobe asserted, `array_addr` is all zeros.
- R2: A rising edge with `ctrl_as_n` low loads `addr_in`, whatever the level of `chip_en`. After that edge, `array_addr` equals the loaded address.
- R3: A rising edge with `proc_as_n` low and `chip_en` high loads `addr_in`. After that edge, `array_addr` equals the loaded address.
- R4: When `proc_as_n` is low and `chip_en` is low, the processor strobe has no effect. With `ctrl_as_n` and `adv_n` high, `array_addr` keeps its previous value.
- R5: With `order_sel` = 0 (linear), the low two bits after k advances are (start + k) mod 4.
- R6: With `order_sel` = 1 (interleaved), the low two bits after k advances are start XOR k.
- R7: After the fourth advance, the low bits return to the starting low bits.
- R8: During a burst, bits `ADDR_W-1:2` of `array_addr` keep the loaded upper address bits.
- R9: When `adv_n` is high and no strobe is active, the address is held (burst suspend).
- R10: A strobe that loads takes priority over `adv_n` low in the same cycle. The new address appears at beat 0.
- R11: `order_sel` is not clocked. A change on it moves `array_addr` to the other ordering within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | External address bus |
| proc_as_n | input | 1 | Processor-side address strobe, active low, qualified by chip_en |
| ctrl_as_n | input | 1 | Controller-side address strobe, active low, not qualified |
| adv_n | input | 1 | Burst advance, active low |
| chip_en | input | 1 | Chip-enable qualifier for the processor strobe |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static, not clocked) |
| array_addr | output | ADDR_W | Internal array address |

## Verification
Loads, advances and holds all act through registers. Their result is due in the cycle after the edge that samples them. The bench drives inputs just after a falling edge and checks `array_addr` at the next falling edge, half a period after the register updates. The order-select result is combinational. That check changes the pin mid-cycle and samples a short delay later, with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } order_e;

   // Linear: the beat offset is added to the start, wrapping within the burst
   function automatic logic [7:0] lin_step(input logic [7:0] start, input logic [7:0] beat);
      return start + beat;
   endfunction

endpackage

// File: rtl/sbs_start_reg.sv
module sbs_start_reg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] start_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     start_q <= '0;
      else if (load)  start_q <= addr_in;
   end

endmodule

// File: rtl/sbs_beat_ctr.sv
module sbs_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      beat_q <= '0;
      else if (clear)  beat_q <= '0;
      else if (step)   beat_q <= beat_q + ONE;
   end

endmodule

// File: rtl/sbs_order_map.sv
module sbs_order_map
   import sbs_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   input  logic              order_sel,
   output logic [BEAT_W-1:0] low_addr
);

   logic [BEAT_W-1:0] lin_lo;
   logic [BEAT_W-1:0] ilv_lo;
   order_e            order;

   assign order = order_e'(order_sel);

   // Interleaved ordering: each bit is flipped by the matching beat bit
   for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
      assign ilv_lo[i] = start_lo[i] ^ beat[i];
   end

   logic [7:0] lin_full;
   assign lin_full = lin_step(8'(start_lo), 8'(beat));
   assign lin_lo   = lin_full[BEAT_W-1:0];

   always_comb begin
      case (order)
         ORD_INTERLEAVED: low_addr = ilv_lo;
         default:         low_addr = lin_lo;
      endcase
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              proc_as_n,
   input  logic              ctrl_as_n,
   input  logic              adv_n,
   input  logic              chip_en,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] array_addr
);

   if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
      $error("BEAT_W must lie between 1 and 8");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("ADDR_W must exceed BEAT_W");
   end

   logic              load;
   logic              step;
   logic [ADDR_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_addr;

   assign load = !ctrl_as_n || (!proc_as_n && chip_en);
   assign step = !load && !adv_n;

   sbs_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_in (addr_in),
      .start_q (start_q)
   );

   sbs_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (load),
      .step   (step),
      .beat_q (beat_q)
   );

   sbs_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start_lo  (start_q[BEAT_W-1:0]),
      .beat      (beat_q),
      .order_sel (order_sel),
      .low_addr  (low_addr)
   );

   assign array_addr = {start_q[ADDR_W-1:BEAT_W], low_addr};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic              proc_as_n,
   input logic              ctrl_as_n,
   input logic              adv_n,
   input logic              chip_en,
   input logic              order_sel,
   input logic [ADDR_W-1:0] array_addr
);

   logic no_load;
   assign no_load = ctrl_as_n && (proc_as_n || !chip_en);

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_as_n |=> array_addr == $past(addr_in)); // R2

   AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_as_n && chip_en) |=> array_addr == $past(addr_in)); // R3

   AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_as_n && !proc_as_n && !chip_en && adv_n) |=> (!$stable(order_sel) || $stable(array_addr))); // R4

   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && adv_n) |=> (!$stable(order_sel) || $stable(array_addr))); // R9

   AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      no_load |=> $stable(array_addr[ADDR_W-1:BEAT_W])); // R8

   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && !adv_n && !order_sel) |=>
         (order_sel || array_addr[BEAT_W-1:0] == BEAT_W'($past(array_addr[BEAT_W-1:0]) + 1'b1))); // R5

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_in;
   logic          proc_as_n, ctrl_as_n, adv_n, chip_en, order_sel;
   logic [AW-1:0] array_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_as_n(proc_as_n),
      .ctrl_as_n(ctrl_as_n), .adv_n(adv_n), .chip_en(chip_en),
      .order_sel(order_sel), .array_addr(array_addr)
   );

   task automatic check(input string req, input logic [AW-1:0] exp);
      checks++;
      if (array_addr !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, array_addr, exp);
      end
   endtask

   task automatic tick(input logic sp_n, input logic sc_n, input logic av_n,
                       input logic ce, input logic [AW-1:0] a);
      proc_as_n = sp_n; ctrl_as_n = sc_n; adv_n = av_n; chip_en = ce; addr_in = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int k, input logic ilv);
      logic [1:0] lo;
      lo = ilv ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
      return {s[AW-1:2], lo};
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      rst_n = 1'b0;
      proc_as_n = 1; ctrl_as_n = 1; adv_n = 1; chip_en = 0; order_sel = 0; addr_in = 16'hFFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", '0);
      rst_n = 1'b1;
      tick(1, 1, 1, 1, 16'h1234);
      check("R1 after reset", '0);

      // Sweep: both orders, every start beat, several upper patterns
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 3; j++) begin
               logic [AW-1:0] base;
               base = {14'(j * 14'h1A4D + 14'h0123), 2'(s)};
               order_sel = m[0];
               tick(1, 0, 1, 0, base);
               check("R2 ctrl load", base);
               for (int k = 1; k <= 4; k++) begin
                  tick(1, 1, 0, 1, ~base);
                  if (k == 4)      check("R7 wrap", base);
                  else if (m == 1) check("R6/R8 interleaved", exp_addr(base, k, 1'b1));
                  else             check("R5/R8 linear", exp_addr(base, k, 1'b0));
               end
               tick(1, 1, 0, 1, ~base);
               tick(1, 1, 1, 1, ~base);
               check("R9 suspend", exp_addr(base, 1, m[0]));
               tick(1, 1, 1, 0, ~base);
               check("R9 suspend again", exp_addr(base, 1, m[0]));
            end
         end
      end

      // Processor strobe, qualified and gated
      order_sel = 0;
      tick(0, 1, 1, 1, 16'hBEE2);
      check("R3 proc load", 16'hBEE2);
      tick(0, 1, 1, 0, 16'h0F0F);
      check("R4 proc gated", 16'hBEE2);
      tick(0, 1, 0, 0, 16'h0F0F);
      check("R4 gated strobe, advance proceeds", 16'hBEE3);

      // Load beats advance in the same cycle
      tick(1, 0, 0, 0, 16'h4441);
      check("R10 ctrl over advance", 16'h4441);
      tick(0, 1, 0, 1, 16'h7772);
      check("R10 proc over advance", 16'h7772);

      // Unclocked order select
      tick(1, 0, 1, 0, 16'hA5A1);
      tick(1, 1, 0, 1, 16'h0000);
      check("R11 linear before switch", 16'hA5A2);
      order_sel = 1'b1;
      #2;
      check("R11 interleaved after switch", 16'hA5A0);
      order_sel = 1'b0;
      #2;
      check("R11 linear after switch back", 16'hA5A2);

      done = 1;
      summary();
   end

endmodule